// File: doc/BRIEF.md
# Conversion Result Register Bank

This block stores conversion results for one converter group. It holds a bank of result registers. Each incoming result carries the index of the register it is meant for. Every register has its own valid flag and can optionally refuse new data while it still holds an unread result. The reader addresses one register and gives a read strobe, which consumes that register's content.

Neighbouring registers can be linked into a first-in first-out chain. Results are written into the top register of a chain and step down one register per cycle toward the bottom register, where the reader takes them oldest first. Incoming samples can be reduced to 10 or 8 bits. They can also be summed over up to four conversions before a result counts as complete. A one-cycle event pulse tells the system that a result has reached a register it can read.

Top module: `result_bank`

## Requirements
- R1: After reset every register is invalid, `event_o` is all zero and `lost_o` is all zero.
- R2: A completed write to an unlinked register makes it valid, and its data appear on `rd_data_o` when it is addressed. A read strobe on that register clears its valid flag.
- R3: When `wfr_en_i[k]` is set and register k holds unread data, a completing write to k is discarded and the stored data stay unchanged.
- R4: A write discarded under R3 sets `lost_o[k]`. The flag stays set until a read strobe addresses register k, which clears it.
- R5: When `wfr_en_i[k]` is clear, a completing write replaces unread data in register k, and `lost_o[k]` stays clear.
- R6: `res_mode_i` selects the stored resolution, right-aligned. Value 0 keeps all 12 bits, 1 keeps `wr_data_i[11:2]`, 2 keeps `wr_data_i[11:4]`, and 3 behaves as 0.
- R7: With `acc_last_i` = n-1, the register adds n successive samples before it becomes valid and shows their 14-bit sum. Until then it stays invalid.
- R8: `event_o[k]` is high for exactly the one cycle after a result is loaded into register k, and only when k is an output stage, meaning `link_i[k-1]` is clear or k is 0.
- R9: `link_i[k]`=1 makes register k+1 feed register k. A result moves down one stage on each clock edge at which the next stage is empty, and reads at the lowest stage return results in write order.
- R10: A write addressed to register k while `link_i[k]` is set (k is not the input end of its chain) is discarded.
- R11: Under R3, when every stage of a chain is full, a write to its input stage is dropped and sets `lost_o` for that stage, and the queued results are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Result write strobe |
| wr_idx_i | input | 4 | Target register of the write |
| wr_data_i | input | 12 | Raw conversion result |
| res_mode_i | input | 2 | Stored resolution select |
| acc_last_i | input | 2 | Number of accumulated samples minus one |
| wfr_en_i | input | 16 | Per-register wait-for-read enable |
| link_i | input | 15 | Bit k links register k+1 into register k |
| rd_strobe_i | input | 1 | Read strobe, consumes the addressed register |
| rd_idx_i | input | 4 | Register addressed for reading |
| rd_data_o | output | 14 | Content of the addressed register |
| rd_valid_o | output | 1 | Valid flag of the addressed register |
| event_o | output | 16 | One-cycle result-available pulse per register |
| lost_o | output | 16 | Sticky discarded-write flag per register |

## Verification
The hardest state to reach is a full chain whose input stage refuses data. Writes that come in back to back leave gaps, because a stage only drains once the stage below it was already empty at the clock edge. The bench therefore spaces its chain writes four cycles apart so that each result settles at the lowest free stage, then adds one more write than the chain has stages. The queued results are then drained through a scoreboard that compares them in order.

// File: rtl/result_bank_pkg.sv
package result_bank_pkg;
  typedef enum logic [1:0] {
    RES_FULL  = 2'd0,
    RES_MID   = 2'd1,
    RES_LOW   = 2'd2,
    RES_FULL2 = 2'd3
  } res_mode_e;
endpackage

// File: rtl/rrb_scale.sv
module rrb_scale
  import result_bank_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W-1:0] raw_i,
  input  logic [1:0]        mode_i,
  output logic [DATA_W-1:0] smp_o
);
  localparam int SH_MID = DATA_W - 10;
  localparam int SH_LOW = DATA_W - 8;

  res_mode_e mode;
  assign mode = res_mode_e'(mode_i);

  always_comb begin
    case (mode)
      RES_MID: smp_o = raw_i >> SH_MID;
      RES_LOW: smp_o = raw_i >> SH_LOW;
      default: smp_o = raw_i;
    endcase
  end
endmodule

// File: rtl/rrb_stage.sv
module rrb_stage #(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 2,
  parameter int ACC_W  = DATA_W + CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hit_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [CNT_W-1:0]  acc_last_i,
  input  logic              wfr_i,
  input  logic              up_link_i,
  input  logic              up_valid_i,
  input  logic [ACC_W-1:0]  up_data_i,
  input  logic              down_link_i,
  input  logic              down_valid_i,
  input  logic              rd_hit_i,
  output logic              valid_o,
  output logic [ACC_W-1:0]  data_o,
  output logic              lost_o,
  output logic              event_o
);
  logic [ACC_W-1:0] acc_q, data_q, sum;
  logic [CNT_W-1:0] cnt_q;
  logic valid_q, lost_q, event_q;
  logic move_in, move_out, last_smp, blocked, commit, drop, load;

  assign move_in  = up_link_i & up_valid_i & ~valid_q;
  assign move_out = down_link_i & valid_q & ~down_valid_i;
  assign sum      = acc_q + ACC_W'(sample_i);
  assign last_smp = wr_hit_i & (cnt_q >= acc_last_i);
  // a read or a departure in the same cycle frees the slot
  assign blocked  = valid_q & wfr_i & ~rd_hit_i & ~move_out;
  assign commit   = last_smp & ~blocked;
  assign drop     = last_smp & blocked;
  assign load     = commit | move_in;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      lost_q  <= 1'b0;
      event_q <= 1'b0;
    end else begin
      if (wr_hit_i) begin
        if (last_smp) begin
          acc_q <= '0;
          cnt_q <= '0;
        end else begin
          acc_q <= sum;
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
      if (commit)       data_q <= sum;
      else if (move_in) data_q <= up_data_i;
      if (load)                     valid_q <= 1'b1;
      else if (rd_hit_i | move_out) valid_q <= 1'b0;
      if (drop)          lost_q <= 1'b1;
      else if (rd_hit_i) lost_q <= 1'b0;
      event_q <= load & ~down_link_i;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign lost_o  = lost_q;
  assign event_o = event_q;

  AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit_i && !wr_hit_i && !up_link_i |=> !valid_q); // R2
  AST_WFR_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && wfr_i && !rd_hit_i && !move_out |=> $stable(data_q)); // R3
  AST_LOST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_q && !rd_hit_i |=> lost_q); // R4
  AST_EVT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_q |-> valid_q); // R8
endmodule

// File: rtl/rrb_read_mux.sv
module rrb_read_mux #(
  parameter int N     = 16,
  parameter int ACC_W = 14,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             rd_strobe_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [N-1:0]     valid_i,
  input  logic [ACC_W-1:0] data_i [N],
  output logic [N-1:0]     rd_hit_o,
  output logic [ACC_W-1:0] rd_data_o,
  output logic             rd_valid_o
);
  for (genvar k = 0; k < N; k++) begin : g_hit
    assign rd_hit_o[k] = rd_strobe_i && (rd_idx_i == IDX_W'(k));
  end

  always_comb begin
    rd_data_o  = '0;
    rd_valid_o = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (rd_idx_i == IDX_W'(k)) begin
        rd_data_o  = data_i[k];
        rd_valid_o = valid_i[k];
      end
    end
  end
endmodule

// File: rtl/result_bank.sv
module result_bank #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 12,
  parameter int CNT_W    = 2,
  parameter int IDX_W    = $clog2(NUM_REGS),
  parameter int ACC_W    = DATA_W + CNT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_valid_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [1:0]          res_mode_i,
  input  logic [CNT_W-1:0]    acc_last_i,
  input  logic [NUM_REGS-1:0] wfr_en_i,
  input  logic [NUM_REGS-2:0] link_i,
  input  logic                rd_strobe_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [ACC_W-1:0]    rd_data_o,
  output logic                rd_valid_o,
  output logic [NUM_REGS-1:0] event_o,
  output logic [NUM_REGS-1:0] lost_o
);
  logic [DATA_W-1:0]   smp;
  logic [NUM_REGS-1:0] valid_w, rd_hit, wr_hit, up_link, down_link, up_valid, down_valid;
  logic [ACC_W-1:0]    data_w [NUM_REGS];
  logic [ACC_W-1:0]    up_data [NUM_REGS];

  rrb_scale #(.DATA_W(DATA_W)) u_scale (
    .raw_i(wr_data_i), .mode_i(res_mode_i), .smp_o(smp)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    if (k < NUM_REGS - 1) begin : g_up
      assign up_link[k]  = link_i[k];
      assign up_valid[k] = valid_w[k+1];
      assign up_data[k]  = data_w[k+1];
    end else begin : g_top
      assign up_link[k]  = 1'b0;
      assign up_valid[k] = 1'b0;
      assign up_data[k]  = '0;
    end
    if (k > 0) begin : g_dn
      assign down_link[k]  = link_i[k-1];
      assign down_valid[k] = valid_w[k-1];
    end else begin : g_bot
      assign down_link[k]  = 1'b0;
      assign down_valid[k] = 1'b0;
    end
    // only the input end of a chain accepts writes
    assign wr_hit[k] = wr_valid_i && (wr_idx_i == IDX_W'(k)) && !up_link[k];

    rrb_stage #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_stage (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_hit_i    (wr_hit[k]),
      .sample_i    (smp),
      .acc_last_i  (acc_last_i),
      .wfr_i       (wfr_en_i[k]),
      .up_link_i   (up_link[k]),
      .up_valid_i  (up_valid[k]),
      .up_data_i   (up_data[k]),
      .down_link_i (down_link[k]),
      .down_valid_i(down_valid[k]),
      .rd_hit_i    (rd_hit[k]),
      .valid_o     (valid_w[k]),
      .data_o      (data_w[k]),
      .lost_o      (lost_o[k]),
      .event_o     (event_o[k])
    );
  end

  rrb_read_mux #(.N(NUM_REGS), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_rd (
    .rd_strobe_i(rd_strobe_i),
    .rd_idx_i   (rd_idx_i),
    .valid_i    (valid_w),
    .data_i     (data_w),
    .rd_hit_o   (rd_hit),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );
endmodule

// File: tb/result_bank_tb.sv
module result_bank_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [11:0] wr_data = '0;
  logic [1:0]  res_mode = '0;
  logic [1:0]  acc_last = '0;
  logic [15:0] wfr_en = '0;
  logic [14:0] link = '0;
  logic        rd_strobe = 1'b0;
  logic [3:0]  rd_idx = '0;
  logic [13:0] rd_data;
  logic        rd_valid;
  logic [15:0] event_w, lost_w;

  int n_chk = 0;
  int n_fail = 0;
  int ev_cnt [16];
  logic [13:0] exp_q [$];
  string       tag_q [$];
  event        mon_ev;

  always #4 clk = ~clk;

  result_bank u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .res_mode_i(res_mode), .acc_last_i(acc_last),
    .wfr_en_i(wfr_en), .link_i(link), .rd_strobe_i(rd_strobe), .rd_idx_i(rd_idx),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .event_o(event_w), .lost_o(lost_w)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk)
    for (int i = 0; i < 16; i++) ev_cnt[i] += int'(event_w[i]);

  // scoreboard monitor
  initial forever begin
    @(mon_ev);
    if (exp_q.size() == 0) chk("R2 unexpected read", 1, 0);
    else begin
      automatic string t = tag_q.pop_front();
      automatic logic [13:0] e = exp_q.pop_front();
      chk(t, {17'd0, rd_valid, rd_data}, {17'd0, 1'b1, e});
    end
  end

  task automatic expect_item(string t, logic [13:0] d);
    tag_q.push_back(t);
    exp_q.push_back(d);
  endtask

  task automatic wr(int idx, logic [11:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_idx = 4'(idx); wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(int idx);
    @(negedge clk);
    rd_idx = 4'(idx); rd_strobe = 1'b1;
    #1 -> mon_ev;
    @(negedge clk);
    rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic peek(int idx, output logic v);
    rd_idx = 4'(idx);
    #1 v = rd_valid;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_ev();
    for (int i = 0; i < 16; i++) ev_cnt[i] = 0;
  endtask

  initial begin
    #(8 * 100000);
    chk("watchdog", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic v;
    logic allv;
    for (int i = 0; i < 16; i++) ev_cnt[i] = 0;
    idle(3);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 event", event_w, 0);
    chk("R1 lost", lost_w, 0);
    allv = 1'b0;
    for (int i = 0; i < 16; i++) begin peek(i, v); allv |= v; end
    chk("R1 valid", allv, 0);

    // R2 plain write/read, R8 event on standalone
    wr(3, 12'hABC);
    chk("R8 event standalone", event_w, 16'h0008);
    @(negedge clk);
    chk("R8 event one cycle", event_w, 0);
    expect_item("R2 read data", 14'hABC);
    rd(3);
    peek(3, v);
    chk("R2 valid cleared", v, 0);

    // R5 overwrite without wait-for-read
    wr(4, 12'h111);
    wr(4, 12'h222);
    chk("R5 no lost", lost_w[4], 0);
    expect_item("R5 overwritten", 14'h222);
    rd(4);

    // R3/R4 wait-for-read blocks
    wfr_en[5] = 1'b1;
    wr(5, 12'h333);
    wr(5, 12'h444);
    chk("R3 no event on drop", event_w[5], 0);
    chk("R4 lost set", lost_w[5], 1);
    idle(3);
    chk("R4 lost sticky", lost_w[5], 1);
    expect_item("R3 kept data", 14'h333);
    rd(5);
    chk("R4 lost cleared", lost_w[5], 0);
    wfr_en[5] = 1'b0;

    // R6 resolution
    res_mode = 2'd1; wr(6, 12'hABC); expect_item("R6 10 bit", 14'h2AF); rd(6);
    res_mode = 2'd2; wr(6, 12'hABC); expect_item("R6 8 bit", 14'h0AB); rd(6);
    res_mode = 2'd3; wr(6, 12'hABC); expect_item("R6 mode 3", 14'hABC); rd(6);
    res_mode = 2'd0;

    // R7 accumulation of four samples
    acc_last = 2'd3;
    wr(7, 12'hFFF); wr(7, 12'hFFF); wr(7, 12'hFFF);
    peek(7, v);
    chk("R7 not valid early", v, 0);
    chk("R7 no early event", event_w[7], 0);
    wr(7, 12'hFFF);
    chk("R7 event on last", event_w[7], 1);
    expect_item("R7 sum", 14'h3FFC);
    rd(7);
    acc_last = 2'd0;

    // R9 chain 11->10->9->8
    link[8] = 1'b1; link[9] = 1'b1; link[10] = 1'b1;
    clr_ev();
    wr(11, 12'h010); idle(4);
    wr(11, 12'h020); idle(4);
    wr(11, 12'h030); idle(4);
    wr(11, 12'h040); idle(4);
    expect_item("R9 fifo 0", 14'h010);
    expect_item("R9 fifo 1", 14'h020);
    expect_item("R9 fifo 2", 14'h030);
    expect_item("R9 fifo 3", 14'h040);
    for (int i = 0; i < 4; i++) rd(8);
    idle(4);
    chk("R8 events at output", ev_cnt[8], 4);
    chk("R8 none at inner", ev_cnt[9] + ev_cnt[10] + ev_cnt[11], 0);
    peek(8, v);
    chk("R9 drained", v, 0);

    // R10 write to a non-input stage
    wr(9, 12'h777);
    idle(5);
    peek(9, v);
    chk("R10 inner ignored", v, 0);
    peek(8, v);
    chk("R10 nothing flows", v, 0);

    // R11 full chain with wait-for-read at input
    wfr_en[11] = 1'b1;
    wr(11, 12'h050); idle(4);
    wr(11, 12'h060); idle(4);
    wr(11, 12'h070); idle(4);
    wr(11, 12'h080); idle(4);
    chk("R11 no lost yet", lost_w[11], 0);
    wr(11, 12'h090);
    chk("R11 lost on full", lost_w[11], 1);
    expect_item("R11 fifo 0", 14'h050);
    expect_item("R11 fifo 1", 14'h060);
    expect_item("R11 fifo 2", 14'h070);
    expect_item("R11 fifo 3", 14'h080);
    for (int i = 0; i < 4; i++) begin rd(8); idle(3); end
    peek(8, v);
    chk("R11 dropped item absent", v, 0);
    chk("R11 scoreboard empty", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule